// File: doc/BRIEF.md
# Unsigned Multiply-Add Carry-Chain Unit

This block multiplies two unsigned operands `a_i` and `b_i`, adds a third unsigned operand `c_i` to the double-width product, and returns the double-width sum as two halves. `lo_o` carries the low half. `hi_o` carries the high half. `c_i` is zero-extended to double width before the addition: it is neither shifted nor sign-extended.

The high half is meant to come back as `c_i` on the next operation. Software can therefore run a scalar-by-vector big-integer multiply one limb at a time. It feeds each vector limb into `a_i` and the scalar into `b_i`, starting the chain with `c_i` at zero, and stores each `lo_o` as one limb of the result. After the last limb, `hi_o` holds the top limb. The sum can never exceed the double-width range, so the block has no overflow or status output.

A one-cycle `start_i` pulse latches the operands and the unit begins working. The multiply is an iterative shift-add that retires `STEP_BITS` multiplier bits per cycle. The result appears `DATA_W/STEP_BITS` cycles later on registered outputs, which hold their value until the next completion.

Top module: `madd_chain_unit`

## Requirements
- R1: At completion, `lo_o` equals bits DATA_W-1:0 of `a*b + c`, with all three operands taken as unsigned.
- R2: At completion, `hi_o` equals bits 2*DATA_W-1:DATA_W of `a*b + c`.
- R3: `c_i` is zero-extended: with `a_i` = 0 and `c_i` all ones, `lo_o` is all ones and `hi_o` is 0.
- R4: `done_o` is high for exactly one cycle, DATA_W/STEP_BITS clock edges after the edge that accepted `start_i`.
- R5: `busy_o` is high from the edge that accepts `start_i` until `done_o` rises, and `busy_o` is low whenever `done_o` is high.
- R6: A `start_i` pulse while `busy_o` is high is ignored: it produces no extra `done_o`, and the result depends only on the operands latched at acceptance. Operand inputs changed after acceptance also have no effect.
- R7: `lo_o` and `hi_o` stay constant in every cycle in which `done_o` is low.
- R8: With all operands all ones, the result fits without overflow: `hi_o` is all ones and `lo_o` is 0.
- R9: Feeding each `hi_o` back as the next `c_i`, starting from 0, yields the exact big-integer product of a multi-limb vector and a scalar.
- R10: After reset, `busy_o` and `done_o` are 0 and `lo_o` and `hi_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept operands and begin, when the unit is idle |
| a_i | input | DATA_W | Multiplicand |
| b_i | input | DATA_W | Multiplier |
| c_i | input | DATA_W | Addend, the carry-in of a chain |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the results update |
| lo_o | output | DATA_W | Low half of the sum |
| hi_o | output | DATA_W | High half of the sum, the carry-out of a chain |

## Verification
The bench builds the unit with DATA_W = 64 and STEP_BITS = 1, the one-bit-per-cycle form. Every multiplier bit therefore passes through its own add step, and the latency is the full 64 cycles. With these values the all-ones operands give the largest possible sum, the top carry bit of the accumulator is exercised, and a four-limb chain reaches a 320-bit product. These are compared against wide reference arithmetic computed in the bench.

// File: rtl/madd_pkg.sv
package madd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } madd_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/madd_ctrl.sv
module madd_ctrl
  import madd_pkg::*;
#(
  parameter int unsigned STEPS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = cnt_width(STEPS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEPS - 1);

  madd_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic done_q;

  always_comb begin
    load_o  = 1'b0;
    step_o  = 1'b0;
    last_o  = 1'b0;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        load_o = start_i;
        if (start_i) state_d = ST_RUN;
      end
      ST_RUN: begin
        step_o = 1'b1;
        last_o = (cnt_q == CNT_LAST);
        if (last_o) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= step_o & last_o;
      if (load_o)      cnt_q <= '0;
      else if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/madd_pp.sv
module madd_pp #(
  parameter int unsigned ACC_W     = 128,
  parameter int unsigned STEP_BITS = 1
) (
  input  logic [ACC_W-1:0]     mcand_i,
  input  logic [STEP_BITS-1:0] digit_i,
  output logic [ACC_W-1:0]     pp_o
);
  logic [ACC_W-1:0] term [STEP_BITS];

  for (genvar j = 0; j < STEP_BITS; j++) begin : g_term
    assign term[j] = digit_i[j] ? (mcand_i << j) : '0;
  end

  always_comb begin
    pp_o = '0;
    for (int j = 0; j < STEP_BITS; j++) pp_o = pp_o + term[j];
  end
endmodule

// File: rtl/madd_datapath.sv
module madd_datapath #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned STEP_BITS = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  step_i,
  input  logic [DATA_W-1:0]     a_i,
  input  logic [DATA_W-1:0]     b_i,
  input  logic [DATA_W-1:0]     c_i,
  output logic [2*DATA_W-1:0]   sum_o
);
  localparam int unsigned ACC_W = 2 * DATA_W;

  logic [ACC_W-1:0]  acc_q, mcand_q, pp;
  logic [DATA_W-1:0] mplier_q;

  madd_pp #(.ACC_W(ACC_W), .STEP_BITS(STEP_BITS)) u_pp (
    .mcand_i (mcand_q),
    .digit_i (mplier_q[STEP_BITS-1:0]),
    .pp_o    (pp)
  );

  assign sum_o = acc_q + pp;

  // addend preloaded into the accumulator; multiplicand walks left
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (load_i) begin
      acc_q    <= {{DATA_W{1'b0}}, c_i};
      mcand_q  <= {{DATA_W{1'b0}}, a_i};
      mplier_q <= b_i;
    end else if (step_i) begin
      acc_q    <= sum_o;
      mcand_q  <= mcand_q << STEP_BITS;
      mplier_q <= mplier_q >> STEP_BITS;
    end
  end
endmodule

// File: rtl/madd_chain_unit.sv
module madd_chain_unit #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned STEP_BITS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  localparam int unsigned STEPS = DATA_W / STEP_BITS;

  logic load, step, last;
  logic [2*DATA_W-1:0] sum;
  logic [DATA_W-1:0] lo_q, hi_q;

  madd_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  madd_datapath #(.DATA_W(DATA_W), .STEP_BITS(STEP_BITS)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (c_i),
    .sum_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (step && last) begin
      lo_q <= sum[DATA_W-1:0];
      hi_q <= sum[2*DATA_W-1:DATA_W];
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/madd_chain_unit_chk.sv
module madd_chain_unit_chk #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned STEP_BITS = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] c_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] lo_o,
  input logic [DATA_W-1:0] hi_o
);
  localparam int unsigned STEPS = DATA_W / STEP_BITS;

  int unsigned run_cnt;
  logic [DATA_W-1:0] a_l, b_l, c_l;
  logic [2*DATA_W-1:0] ref_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt <= 0;
      a_l <= '0;
      b_l <= '0;
      c_l <= '0;
    end else if (start_i && !busy_o) begin
      run_cnt <= 0;
      a_l <= a_i;
      b_l <= b_i;
      c_l <= c_i;
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1;
    end
  end

  assign ref_sum = {{DATA_W{1'b0}}, a_l} * {{DATA_W{1'b0}}, b_l} + {{DATA_W{1'b0}}, c_l};

  a_r1_low_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lo_o == ref_sum[DATA_W-1:0]);
  a_r2_high_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> hi_o == ref_sum[2*DATA_W-1:DATA_W]);
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_cnt == STEPS);
  a_r5_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r5_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(lo_o) && $stable(hi_o)));
endmodule

bind madd_chain_unit madd_chain_unit_chk #(.DATA_W(DATA_W), .STEP_BITS(STEP_BITS)) u_chk (.*);

// File: tb/tb_madd_chain_unit.sv
module tb_madd_chain_unit;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned STEP_BITS = 1;
  localparam int unsigned STEPS     = DATA_W / STEP_BITS;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned LIMBS     = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [DATA_W-1:0] a_i = '0, b_i = '0, c_i = '0;
  logic busy_o, done_o;
  logic [DATA_W-1:0] lo_o, hi_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  madd_chain_unit #(.DATA_W(DATA_W), .STEP_BITS(STEP_BITS)) dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i),
    .a_i (a_i), .b_i (b_i), .c_i (c_i),
    .busy_o (busy_o), .done_o (done_o), .lo_o (lo_o), .hi_o (hi_o)
  );

  function automatic logic [2*DATA_W-1:0] ref_madd(input logic [DATA_W-1:0] a, b, c);
    logic [2*DATA_W-1:0] wa, wb, wc;
    wa = {{DATA_W{1'b0}}, a};
    wb = {{DATA_W{1'b0}}, b};
    wc = {{DATA_W{1'b0}}, c};
    return wa * wb + wc;
  endfunction

  function automatic logic [DATA_W-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // poke > 0: pulse start with other operands at that cycle of the run (R6)
  task automatic run_op(input logic [DATA_W-1:0] a, b, c, input int poke,
                        output logic [DATA_W-1:0] lo, output logic [DATA_W-1:0] hi);
    int cyc;
    int extra_done;
    @(negedge clk_i);
    a_i = a; b_i = b; c_i = c; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    a_i = rnd_word(); b_i = rnd_word(); c_i = rnd_word();
    cyc = 1;
    extra_done = 0;
    check("R5 busy after accept", 128'(busy_o), 128'(1));
    while (!done_o && cyc < 5000) begin
      if (cyc == poke) begin
        start_i = 1'b1; a_i = ~a; b_i = ~b; c_i = ~c;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    check("R4 latency", 128'(cyc - 1), 128'(STEPS));
    check("R5 busy low at done", 128'(busy_o), 128'(0));
    lo = lo_o;
    hi = hi_o;
    @(negedge clk_i);
    if (done_o) extra_done++;
    check("R4 done single cycle", 128'(extra_done), 128'(0));
  endtask

  task automatic op_check(input string tag, input logic [DATA_W-1:0] a, b, c, input int poke);
    logic [DATA_W-1:0] lo, hi;
    logic [2*DATA_W-1:0] e;
    run_op(a, b, c, poke, lo, hi);
    e = ref_madd(a, b, c);
    check({tag, " R1 low"}, 128'(lo), 128'(e[DATA_W-1:0]));
    check({tag, " R2 high"}, 128'(hi), 128'(e[2*DATA_W-1:DATA_W]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] lo, hi, lo0, hi0;
    logic [DATA_W*LIMBS-1:0] vec, res;
    logic [DATA_W-1:0] scal, carry;
    logic [DATA_W*(LIMBS+1)-1:0] big;

    void'($urandom(32'd20241));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 busy", 128'(busy_o), 128'(0));
    check("R10 done", 128'(done_o), 128'(0));
    check("R10 lo", 128'(lo_o), 128'(0));
    check("R10 hi", 128'(hi_o), 128'(0));
    rst_ni = 1'b1;

    op_check("zero", '0, '0, '0, 0);
    op_check("ones-only-b", '0, '1, '0, 0);
    // R3 zero extension
    run_op('0, rnd_word(), '1, 0, lo, hi);
    check("R3 lo is c", 128'(lo), 128'({DATA_W{1'b1}}));
    check("R3 hi zero", 128'(hi), 128'(0));
    // R8 all ones
    run_op('1, '1, '1, 0, lo, hi);
    check("R8 hi all ones", 128'(hi), 128'({DATA_W{1'b1}}));
    check("R8 lo zero", 128'(lo), 128'(0));
    op_check("R8 ones no c", '1, '1, '0, 0);
    op_check("one-times", 64'd1, rnd_word(), rnd_word(), 0);

    // R6 start during busy ignored
    op_check("R6 poke early", rnd_word(), rnd_word(), rnd_word(), 3);
    op_check("R6 poke late", rnd_word(), rnd_word(), rnd_word(), STEPS - 1);

    // R7 hold while inputs wiggle
    lo0 = lo_o; hi0 = hi_o;
    repeat (10) begin
      @(negedge clk_i);
      a_i = rnd_word(); b_i = rnd_word(); c_i = rnd_word();
    end
    check("R7 lo held", 128'(lo_o), 128'(lo0));
    check("R7 hi held", 128'(hi_o), 128'(hi0));

    for (int i = 0; i < 30; i++) begin
      logic [DATA_W-1:0] ra, rb, rc;
      ra = rnd_word(); rb = rnd_word(); rc = rnd_word();
      if (i % 5 == 0) ra[DATA_W-1 -: 8] = 8'hFF;
      op_check("rand", ra, rb, rc, 0);
    end

    // R9 chained scalar-by-vector product
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < LIMBS; i++) vec[i*DATA_W +: DATA_W] = rnd_word();
      scal = (t == 0) ? '1 : rnd_word();
      if (t == 0) vec = '1;
      carry = '0;
      for (int i = 0; i < LIMBS; i++) begin
        run_op(vec[i*DATA_W +: DATA_W], scal, carry, 0, lo, hi);
        res[i*DATA_W +: DATA_W] = lo;
        carry = hi;
      end
      big = {{DATA_W{1'b0}}, vec} * {{(DATA_W*LIMBS){1'b0}}, scal};
      check("R9 chain top limb", 128'(carry), 128'(big[DATA_W*LIMBS +: DATA_W]));
      for (int i = 0; i < LIMBS; i++)
        check("R9 chain limb", 128'(res[i*DATA_W +: DATA_W]), 128'(big[i*DATA_W +: DATA_W]));
    end

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule